// File: doc/BRIEF.md
# Tagged Per-Branch History Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a small tagged table, organised as sets of four ways. Each valid way belongs to one branch and holds three things: that branch's recent outcomes as a short shift register, and a private bank of two-bit saturating counters, one counter for each possible history value. When a branch has been seen before, its own history selects one of its own counters. The top bit of that counter is the prediction. Two branches therefore never train the same counter.

The fetch side presents an address on the lookup port. One cycle later the block returns a valid strobe, a hit flag and the predicted direction. When the branch outcome is known, the execute side presents the branch address and its actual direction on the resolve port. If the resolve hits, it trains the entry. If it misses, it claims a way in the set.

Top module: `local_hist_pred`

## Requirements
- R1: Bits [SET_BITS-1:0] of an address select the set. Bits [ADDR_W-1:SET_BITS] are the tag. A lookup hits only when a valid way in that set holds the same tag, so another address that maps to the same set with a different tag misses.
- R2: A lookup that misses returns pr_hit=0 and pr_taken=0.
- R3: A lookup that hits returns pr_hit=1. It also returns pr_taken equal to the high bit of the counter that the entry's current history selects: 00 and 01 give 0, 10 and 11 give 1.
- R4: Counters saturate. A taken outcome increments a counter up to 11, and a not-taken outcome decrements it down to 00. A counter never wraps at either end.
- R5: A resolve that hits first updates the counter chosen by the history held before the update. The history then shifts left and takes the outcome (1 = taken) into bit 0.
- R6: A resolve that misses installs its tag in a way, with history 0000 and every counter set to 10. The outcome of that resolve is not applied to the new entry.
- R7: The way to fill is the lowest-numbered invalid way. If all four ways are valid, a 3-bit tree picks the way. Root bit 0 selects a pair: 0 gives ways 0/1 and 1 gives ways 2/3. Bit 1 selects within 0/1 and bit 2 selects within 2/3. Every resolve, whether it hits or allocates, points the tree away from the way it used.
- R8: pr_valid, pr_hit and pr_taken are registered. They reflect the lookup presented in the previous cycle, and pr_valid is 0 after a cycle with no lookup.
- R9: A lookup and a resolve in the same cycle to the same entry return the contents held before that resolve.
- R10: Reset invalidates every entry and clears pr_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Lookup fetch address |
| rs_valid | input | 1 | Resolve request |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |
| pr_valid | output | 1 | Lookup result valid |
| pr_hit | output | 1 | Lookup found a matching entry |
| pr_taken | output | 1 | Predicted direction |

## Verification
The assertions assume that the resolve port never installs a tag that is already present in its set. Under that assumption, at most one way of a set matches a given address. The bench stays inside this assumption because it allocates only through resolves that genuinely miss. The stimulus walks one set through filling, eviction, saturation at both ends and same-cycle lookup/resolve collisions, with every expected prediction worked out by hand from the counter and history rules. It also reuses the same addresses across a mid-run reset, which shows that the whole table is invalidated.

// File: rtl/local_hist_pred.sv
module local_hist_pred #(
  parameter int ADDR_W   = 16,
  parameter int SET_BITS = 7,
  parameter int HIST_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              rs_valid,
  input  logic [ADDR_W-1:0] rs_pc,
  input  logic              rs_taken,
  output logic              pr_valid,
  output logic              pr_hit,
  output logic              pr_taken
);
  localparam int SETS    = 1 << SET_BITS;
  localparam int WAYS    = 4;
  localparam int TAG_W   = ADDR_W - SET_BITS;
  localparam int NCTR    = 1 << HIST_W;
  localparam int BANK_W  = 2 * NCTR;
  localparam int ENTRIES = SETS * WAYS;
  localparam int EI_W    = SET_BITS + 2;

  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [HIST_W-1:0] hist_q [ENTRIES];
  logic [BANK_W-1:0] bank_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q;
  logic [2:0]        tree_q [SETS];

  wire [SET_BITS-1:0] lk_set = lk_pc[SET_BITS-1:0];
  wire [TAG_W-1:0]    lk_tag = lk_pc[ADDR_W-1:SET_BITS];
  wire [SET_BITS-1:0] rs_set = rs_pc[SET_BITS-1:0];
  wire [TAG_W-1:0]    rs_tag = rs_pc[ADDR_W-1:SET_BITS];

  logic [WAYS-1:0] lk_hv, rs_hv;
  logic            lk_msb;
  logic [1:0]      hit_way, free_way, tree_way, rs_way;
  logic            any_free;

  always_comb begin
    lk_msb = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      lk_hv[w] = valid_q[{lk_set, w[1:0]}] && (tag_q[{lk_set, w[1:0]}] == lk_tag);
      rs_hv[w] = valid_q[{rs_set, w[1:0]}] && (tag_q[{rs_set, w[1:0]}] == rs_tag);
      if (lk_hv[w])
        lk_msb = bank_q[{lk_set, w[1:0]}][{hist_q[{lk_set, w[1:0]}], 1'b1}];
    end
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    any_free = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (rs_hv[w]) hit_way = w[1:0];
      if (!valid_q[{rs_set, w[1:0]}]) begin
        free_way = w[1:0];
        any_free = 1'b1;
      end
    end
  end

  wire [2:0] rs_tree = tree_q[rs_set];
  assign tree_way = rs_tree[0] ? {1'b1, rs_tree[2]} : {1'b0, rs_tree[1]};

  wire rs_hit = |rs_hv;
  assign rs_way = rs_hit ? hit_way : (any_free ? free_way : tree_way);

  wire [EI_W-1:0]   rs_e    = {rs_set, rs_way};
  wire [HIST_W-1:0] rs_h    = hist_q[rs_e];
  wire [1:0]        ctr_old = bank_q[rs_e][{rs_h, 1'b0} +: 2];
  wire [1:0]        ctr_new = rs_taken ? ((ctr_old == 2'b11) ? 2'b11 : ctr_old + 2'b01)
                                       : ((ctr_old == 2'b00) ? 2'b00 : ctr_old - 2'b01);

  always_ff @(posedge clk) begin
    if (rs_valid) begin
      if (rs_hit) begin
        bank_q[rs_e][{rs_h, 1'b0} +: 2] <= ctr_new;
        hist_q[rs_e] <= {rs_h[HIST_W-2:0], rs_taken};
      end else begin
        tag_q[rs_e]  <= rs_tag;
        hist_q[rs_e] <= '0;
        bank_q[rs_e] <= {NCTR{2'b10}};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      pr_valid <= 1'b0;
      pr_hit   <= 1'b0;
      pr_taken <= 1'b0;
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else begin
      pr_valid <= lk_valid;
      pr_hit   <= lk_valid && (|lk_hv);
      pr_taken <= lk_valid && (|lk_hv) && lk_msb;
      if (rs_valid) begin
        valid_q[rs_e] <= 1'b1;
        case (rs_way)
          2'd0:    tree_q[rs_set] <= {rs_tree[2], 1'b1, 1'b1};
          2'd1:    tree_q[rs_set] <= {rs_tree[2], 1'b0, 1'b1};
          2'd2:    tree_q[rs_set] <= {1'b1, rs_tree[1], 1'b0};
          default: tree_q[rs_set] <= {1'b0, rs_tree[1], 1'b0};
        endcase
      end
    end
  end

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_hit |-> !pr_taken);

  // R1
  single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_valid |-> $onehot0(rs_hv));

  // R4
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |-> (rs_taken ? (ctr_new >= ctr_old) : (ctr_new <= ctr_old)));

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && rs_hit) |=> (hist_q[$past(rs_e)][0] == $past(rs_taken)));

  // R6
  alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_hit) |=> valid_q[$past(rs_e)]);
endmodule

// File: tb/local_hist_pred_test.sv
module local_hist_pred_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [15:0] lk_pc = '0;
  logic        rs_valid = 1'b0;
  logic [15:0] rs_pc = '0;
  logic        rs_taken = 1'b0;
  logic        pr_valid, pr_hit, pr_taken;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  local_hist_pred uut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc),
    .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_taken(pr_taken)
  );

  // op: 0 lookup, 1 resolve, 2 both; tail = {taken, exp_hit, exp_pred}
  // A=0005 B=0085 C=0105 D=0185 E=0205 share set 5; F=0006
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 16'h0005, 3'b000},  // R2 cold miss
    {2'd1, 16'h0005, 3'b100},  // R6 allocate A way0
    {2'd0, 16'h0005, 3'b011},  // R6 fresh counters 10
    {2'd1, 16'h0005, 3'b000},  // R5 ctr0 10->01
    {2'd0, 16'h0005, 3'b010},  // R3 ctr0=01
    {2'd1, 16'h0005, 3'b100},  // ctr0 01->10, h=0001
    {2'd0, 16'h0005, 3'b011},  // R5 ctr1=10
    {2'd1, 16'h0005, 3'b000},  // ctr1->01, h=0010
    {2'd0, 16'h0005, 3'b011},  // R5 ctr2=10
    {2'd1, 16'h0005, 3'b000},  // ctr2->01, h=0100
    {2'd1, 16'h0005, 3'b000},  // ctr4->01, h=1000
    {2'd1, 16'h0005, 3'b000},  // ctr8->01, h=0000
    {2'd1, 16'h0005, 3'b000},  // ctr0 10->01
    {2'd1, 16'h0005, 3'b000},  // ctr0 01->00
    {2'd1, 16'h0005, 3'b000},  // R4 ctr0 stays 00
    {2'd0, 16'h0005, 3'b010},  // R4 no wrap below 00
    {2'd1, 16'h0005, 3'b100},  // ctr0 00->01, h=0001
    {2'd0, 16'h0005, 3'b010},  // R3 ctr1=01
    {2'd0, 16'h0085, 3'b000},  // R1 same set, other tag
    {2'd1, 16'h0085, 3'b100},  // allocate B way1
    {2'd0, 16'h0085, 3'b011},
    {2'd0, 16'h0005, 3'b010},  // R1 A untouched
    {2'd1, 16'h0105, 3'b100},  // C way2
    {2'd1, 16'h0185, 3'b100},  // D way3
    {2'd0, 16'h0105, 3'b011},
    {2'd0, 16'h0185, 3'b011},
    {2'd1, 16'h0005, 3'b100},  // A hit: ctr1->10, h=0011, tree -> 011
    {2'd1, 16'h0205, 3'b100},  // R7 E evicts way2 (C)
    {2'd0, 16'h0105, 3'b000},  // R7 C gone
    {2'd0, 16'h0205, 3'b011},
    {2'd0, 16'h0185, 3'b011},  // R7 D kept
    {2'd0, 16'h0085, 3'b011},  // R7 B kept
    {2'd0, 16'h0005, 3'b011},  // R5 A ctr3=10
    {2'd1, 16'h0205, 3'b100},  // E h->0001
    {2'd1, 16'h0205, 3'b100},  // h->0011
    {2'd1, 16'h0205, 3'b100},  // h->0111
    {2'd1, 16'h0205, 3'b100},  // h->1111
    {2'd1, 16'h0205, 3'b100},  // ctr15 10->11
    {2'd1, 16'h0205, 3'b100},  // R4 ctr15 stays 11
    {2'd0, 16'h0205, 3'b011},  // R4 no wrap above 11
    {2'd2, 16'h0085, 3'b011},  // R9 old ctr0=10 seen, then ->01
    {2'd0, 16'h0085, 3'b010},  // R9 update landed
    {2'd2, 16'h0006, 3'b100},  // R9 lookup misses while allocating
    {2'd0, 16'h0006, 3'b011},
    {2'd1, 16'h0085, 3'b000},  // B ctr0 01->00
    {2'd0, 16'h0085, 3'b010},  // B h=0000 still, ctr0 00
    {2'd1, 16'h0085, 3'b100},  // B ctr0->01 h=0001
    {2'd0, 16'h0085, 3'b011},  // B ctr1=10
    {2'd1, 16'h0006, 3'b000},
    {2'd0, 16'h0006, 3'b010}
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", pr_valid, 1'b0, "pr_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][20:19];
      lk_valid = (op != 2'd1);
      rs_valid = (op != 2'd0);
      lk_pc    = VEC[i][18:3];
      rs_pc    = VEC[i][18:3];
      rs_taken = VEC[i][2];
      @(posedge clk);
      @(negedge clk);
      lk_valid = 1'b0;
      rs_valid = 1'b0;
      chk("R8", pr_valid, (op != 2'd1), $sformatf("pr_valid step %0d", i));
      if (op != 2'd1) begin
        chk(VEC[i][1] ? "R3" : "R2", pr_hit, VEC[i][1], $sformatf("hit step %0d", i));
        chk(VEC[i][1] ? "R3" : "R2", pr_taken, VEC[i][0], $sformatf("taken step %0d", i));
      end
    end

    // R10: reset mid-run wipes the table
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", pr_valid, 1'b0, "pr_valid after reset");
    rst_n = 1'b1;
    lk_valid = 1'b1;
    lk_pc = 16'h0005;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R10", pr_hit, 1'b0, "A hit after reset");
    chk("R10", pr_taken, 1'b0, "A taken after reset");

    // R6: reallocation after reset ignores outcome (not-taken resolve, counters 10)
    rs_valid = 1'b1;
    rs_pc = 16'h0005;
    rs_taken = 1'b0;
    @(negedge clk);
    rs_valid = 1'b0;
    lk_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    chk("R6", pr_hit, 1'b1, "A hit after realloc");
    chk("R6", pr_taken, 1'b1, "A taken after realloc");

    finish_up();
  end
endmodule